// File: doc/BRIEF.md
# Test Access Port Controller with Boundary-Scan Instruction Decode

This block is the test access port of a chip. It is clocked by the test clock and steered by the mode-select pin. It holds the sixteen-state controller, a 4-bit instruction register, a one-bit bypass register and a 32-bit identification register. The controller's state is exported on a 4-bit port using a fixed code for each state. Neighbouring debug and test logic decodes that code.

The current instruction is decoded into a set of control strobes for an external boundary-scan chain:

- chain select
- output force-off
- core-input substitution
- pin-output drive
- pulse and train modes

A separate select goes to an instrument-network host. The serial output is chosen from the instruction register during instruction scans. During data scans it comes from the register that the instruction names: the bypass register, the identification register, the boundary-chain return or the instrument-network return.

The data-register capture, shift and update enables and an active-low reset flag are exported for the external chain.

Top module: `tap_bscan_ctrl`

## Requirements
- R1: The state machine follows the standard sixteen-state test-port transitions, and `fsm_code` shows the current state as follows. Reset 1111, idle 1100. Data branch: select 0111, capture 0110, shift 0010, exit-1 0001, pause 0011, exit-2 0000, update 0101. Instruction branch: select 0100, capture 1110, shift 1010, exit-1 1001, pause 1011, exit-2 1000, update 1101.
- R2: `trst` high at a rising `tck` edge forces the reset state, and the instruction becomes 1000 (identification). Five rising edges with `tms` high reach the reset state from any state, with the same effect on the instruction.
- R3: The instruction shift stage loads 0001 in instruction-capture and shifts LSB first from `tdi`. The active instruction takes the shifted value only on the falling `tck` edge while in instruction-update. The decoded strobes do not change at any other time, except in the reset state.
- R4: The opcode map is as follows. 1111 bypass. 0000 clamp. 0001 external test. 0010 external pulse. 0011 external train. 0100 internal test. 0101 sample/preload (one shared code). 0110 high-impedance. 0111 instrument host. 1000 identification. All other codes behave as bypass.
- R5: In data-shift, `tdo` comes from one of four sources. The bypass register serves 1111, 0000, 0110 and every undefined code. `bscan_ret_i` serves 0001 to 0101. `ijtag_ret_i` serves 0111. Identification bit 0 serves 1000.
- R6: In instruction-shift, `tdo` shows bit 0 of the instruction shift stage. A scan therefore first presents the captured 1, 0, 0, 0.
- R7: The bypass register captures 0 in data-capture and gives exactly one stage of delay from `tdi` to `tdo` while shifting.
- R8: The identification register captures {version[3:0], part[15:0], manufacturer[10:0], 1'b1}. It is shifted out LSB first. All fields default to zero, giving 32'h0000_0001.
- R9: `bscan_sel` is high for 0001, 0010, 0011, 0100 and 0101. `ijtag_sel` is high only for 0111.
- R10: The remaining strobes decode as follows. `bs_force_off` is high only for 0110. `bs_core_in` is high only for 0100. `bs_pin_out` is high for 0001, 0010, 0011, 0000 and 0110. `bs_pulse` is high only for 0010, and `bs_train` only for 0011.
- R11: `cap_dr_en`, `shift_dr_en` and `upd_dr_en` are high exactly in data-capture, data-shift and data-update respectively. `tlr_n` is low exactly in the reset state.
- R12: `tdo` and `tdo_en` are registered on the falling `tck` edge. `tdo_en` is high only while in data-shift or instruction-shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| bscan_ret_i | input | 1 | Serial return from the boundary-scan chain |
| ijtag_ret_i | input | 1 | Serial return from the instrument-network host |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Active-high output enable for `tdo` |
| bscan_sel | output | 1 | Boundary chain selected |
| ijtag_sel | output | 1 | Instrument host selected |
| bs_force_off | output | 1 | Force boundary outputs to high impedance |
| bs_core_in | output | 1 | Boundary cells drive core inputs |
| bs_pin_out | output | 1 | Boundary cells drive pins |
| bs_pulse | output | 1 | Pulse mode of external test |
| bs_train | output | 1 | Train mode of external test |
| cap_dr_en | output | 1 | Data-register capture enable |
| shift_dr_en | output | 1 | Data-register shift enable |
| upd_dr_en | output | 1 | Data-register update enable |
| tlr_n | output | 1 | Low while in the reset state |
| fsm_code | output | 4 | Encoded controller state |

## Verification
The bench builds the block with version 4'h5, part 16'hA3C9 and manufacturer 11'h370, so the identification register holds 32'h5A3C_96E1. Reading all 32 bits therefore shows each field in its own bit position, which the all-zero default value would hide. Each opcode, including two undefined codes, is scanned in. The bench then reads the decoded strobes, and a three-bit probe of the return inputs tells apart the four data-return sources. Directed scans cover state-code walking, the bypass delay, the instruction-capture pattern, reset by five `tms` cycles and reset by `trst` in the middle of a scan.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET    = 4'b1111,
        ST_IDLE     = 4'b1100,
        ST_DR_SEL   = 4'b0111,
        ST_DR_CAP   = 4'b0110,
        ST_DR_SHIFT = 4'b0010,
        ST_DR_EXIT1 = 4'b0001,
        ST_DR_PAUSE = 4'b0011,
        ST_DR_EXIT2 = 4'b0000,
        ST_DR_UPD   = 4'b0101,
        ST_IR_SEL   = 4'b0100,
        ST_IR_CAP   = 4'b1110,
        ST_IR_SHIFT = 4'b1010,
        ST_IR_EXIT1 = 4'b1001,
        ST_IR_PAUSE = 4'b1011,
        ST_IR_EXIT2 = 4'b1000,
        ST_IR_UPD   = 4'b1101
    } tap_state_e;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_CLAMP   = 4'b0000;
    localparam opcode_t OP_EXT     = 4'b0001;
    localparam opcode_t OP_EXT_PLS = 4'b0010;
    localparam opcode_t OP_EXT_TRN = 4'b0011;
    localparam opcode_t OP_INT     = 4'b0100;
    localparam opcode_t OP_SAMPLE  = 4'b0101;
    localparam opcode_t OP_HIGHZ   = 4'b0110;
    localparam opcode_t OP_HOST    = 4'b0111;
    localparam opcode_t OP_IDENT   = 4'b1000;
    localparam opcode_t OP_BYPASS  = 4'b1111;

    localparam opcode_t IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        RET_BYPASS,
        RET_BSCAN,
        RET_HOST,
        RET_IDENT
    } ret_sel_e;

    typedef struct packed {
        logic     chain_sel;
        logic     host_sel;
        logic     force_off;
        logic     core_in;
        logic     pin_out;
        logic     pulse;
        logic     train;
        ret_sel_e ret;
    } insn_ctrl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        case (s)
            ST_RESET:    return tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     return tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   return tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   return tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: return tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: return tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: return tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: return tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   return tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   return tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   return tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: return tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: return tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: return tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: return tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   return tms ? ST_DR_SEL   : ST_IDLE;
            default:     return ST_RESET;
        endcase
    endfunction

    function automatic insn_ctrl_t insn_decode(input opcode_t op);
        insn_ctrl_t c;
        c = '{chain_sel: 1'b0, host_sel: 1'b0, force_off: 1'b0, core_in: 1'b0,
              pin_out: 1'b0, pulse: 1'b0, train: 1'b0, ret: RET_BYPASS};
        case (op)
            OP_CLAMP:   c.pin_out = 1'b1;
            OP_EXT:     begin c.chain_sel = 1'b1; c.pin_out = 1'b1; c.ret = RET_BSCAN; end
            OP_EXT_PLS: begin c.chain_sel = 1'b1; c.pin_out = 1'b1; c.pulse = 1'b1; c.ret = RET_BSCAN; end
            OP_EXT_TRN: begin c.chain_sel = 1'b1; c.pin_out = 1'b1; c.train = 1'b1; c.ret = RET_BSCAN; end
            OP_INT:     begin c.chain_sel = 1'b1; c.core_in = 1'b1; c.ret = RET_BSCAN; end
            OP_SAMPLE:  begin c.chain_sel = 1'b1; c.ret = RET_BSCAN; end
            OP_HIGHZ:   begin c.force_off = 1'b1; c.pin_out = 1'b1; end
            OP_HOST:    begin c.host_sel = 1'b1; c.ret = RET_HOST; end
            OP_IDENT:   c.ret = RET_IDENT;
            default:    c.ret = RET_BYPASS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_lsb,
    output opcode_t    active_op
);
    opcode_t shift_q;

    // capture and shift on the rising edge
    always_ff @(posedge tck) begin
        if (rst) begin
            shift_q <= IR_CAPTURE;
        end else if (state == ST_IR_CAP) begin
            shift_q <= IR_CAPTURE;
        end else if (state == ST_IR_SHIFT) begin
            shift_q <= {tdi, shift_q[IR_W-1:1]};
        end
    end

    // the active instruction moves only on the falling edge
    always_ff @(negedge tck) begin
        if (rst || state == ST_RESET) active_op <= OP_IDENT;
        else if (state == ST_IR_UPD)  active_op <= shift_q;
    end

    assign ir_lsb = shift_q[0];
endmodule

// File: rtl/tap_data_regs.sv
module tap_data_regs
    import tap_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       bypass_lsb,
    output logic       ident_lsb
);
    logic            bypass_q;
    logic [ID_W-1:0] ident_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            bypass_q <= 1'b0;
            ident_q  <= ID_VALUE;
        end else if (state == ST_DR_CAP) begin
            bypass_q <= 1'b0;
            ident_q  <= ID_VALUE;
        end else if (state == ST_DR_SHIFT) begin
            bypass_q <= tdi;
            ident_q  <= {tdi, ident_q[ID_W-1:1]};
        end
    end

    assign bypass_lsb = bypass_q;
    assign ident_lsb  = ident_q[0];
endmodule

// File: rtl/tap_bscan_ctrl.sv
module tap_bscan_ctrl
    import tap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h0,
    parameter logic [15:0] ID_PART    = 16'h0000,
    parameter logic [10:0] ID_MFR     = 11'h000
) (
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    input  logic       tdi,
    input  logic       bscan_ret_i,
    input  logic       ijtag_ret_i,
    output logic       tdo,
    output logic       tdo_en,
    output logic       bscan_sel,
    output logic       ijtag_sel,
    output logic       bs_force_off,
    output logic       bs_core_in,
    output logic       bs_pin_out,
    output logic       bs_pulse,
    output logic       bs_train,
    output logic       cap_dr_en,
    output logic       shift_dr_en,
    output logic       upd_dr_en,
    output logic       tlr_n,
    output logic [3:0] fsm_code
);
    localparam int              ID_W     = $bits(ID_VERSION) + $bits(ID_PART) + $bits(ID_MFR) + 1;
    localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

    tap_state_e state;
    opcode_t    active_op;
    insn_ctrl_t ctl;
    logic       ir_lsb, bypass_lsb, ident_lsb;
    logic       dr_bit, out_bit, shifting;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (trst),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck       (tck),
        .rst       (trst),
        .state     (state),
        .tdi       (tdi),
        .ir_lsb    (ir_lsb),
        .active_op (active_op)
    );

    tap_data_regs #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck        (tck),
        .rst        (trst),
        .state      (state),
        .tdi        (tdi),
        .bypass_lsb (bypass_lsb),
        .ident_lsb  (ident_lsb)
    );

    assign ctl = insn_decode(active_op);

    always_comb begin
        case (ctl.ret)
            RET_BSCAN: dr_bit = bscan_ret_i;
            RET_HOST:  dr_bit = ijtag_ret_i;
            RET_IDENT: dr_bit = ident_lsb;
            default:   dr_bit = bypass_lsb;
        endcase
    end

    assign out_bit  = (state == ST_IR_SHIFT) ? ir_lsb : dr_bit;
    assign shifting = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);

    // serial output is retimed to the falling edge
    always_ff @(negedge tck) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= out_bit;
            tdo_en <= shifting;
        end
    end

    assign bscan_sel    = ctl.chain_sel;
    assign ijtag_sel    = ctl.host_sel;
    assign bs_force_off = ctl.force_off;
    assign bs_core_in   = ctl.core_in;
    assign bs_pin_out   = ctl.pin_out;
    assign bs_pulse     = ctl.pulse;
    assign bs_train     = ctl.train;

    assign cap_dr_en   = (state == ST_DR_CAP);
    assign shift_dr_en = (state == ST_DR_SHIFT);
    assign upd_dr_en   = (state == ST_DR_UPD);
    assign tlr_n       = (state != ST_RESET);
    assign fsm_code    = state;
endmodule

// File: rtl/tap_bscan_checker.sv
module tap_bscan_checker
    import tap_pkg::*;
(
    input logic       tck,
    input logic       trst,
    input logic       tms,
    input logic       tdo_en,
    input logic       bscan_sel,
    input logic       ijtag_sel,
    input logic       bs_force_off,
    input logic       bs_core_in,
    input logic       bs_pin_out,
    input logic       bs_pulse,
    input logic       bs_train,
    input logic       cap_dr_en,
    input logic       shift_dr_en,
    input logic       upd_dr_en,
    input logic       tlr_n,
    input logic [3:0] fsm_code
);
    logic [6:0] strobes;
    assign strobes = {bscan_sel, ijtag_sel, bs_force_off, bs_core_in, bs_pin_out, bs_pulse, bs_train};

    p_tlr_hold_r1: assert property (@(posedge tck) disable iff (trst)
        (!tlr_n && tms) |=> !tlr_n);

    p_tlr_leave_r1: assert property (@(posedge tck) disable iff (trst)
        (!tlr_n && !tms) |=> (fsm_code == ST_IDLE));

    p_strobe_hold_r3: assert property (@(posedge tck) disable iff (trst)
        (fsm_code != ST_IR_UPD && fsm_code != ST_RESET) |-> $stable(strobes));

    p_sel_excl_r9: assert property (@(posedge tck) disable iff (trst)
        $onehot0({bscan_sel, ijtag_sel, bs_force_off}));

    p_pulse_train_r10: assert property (@(posedge tck) disable iff (trst)
        (bs_pulse || bs_train) |-> (bs_pin_out && bscan_sel && !bs_core_in));

    p_capture_next_r11: assert property (@(posedge tck) disable iff (trst)
        cap_dr_en |=> (shift_dr_en || fsm_code == ST_DR_EXIT1));

    p_update_next_r11: assert property (@(posedge tck) disable iff (trst)
        upd_dr_en |=> (fsm_code == ST_IDLE || fsm_code == ST_DR_SEL));

    p_tdo_en_r12: assert property (@(posedge tck) disable iff (trst)
        tdo_en == (fsm_code == ST_DR_SHIFT || fsm_code == ST_IR_SHIFT));
endmodule

bind tap_bscan_ctrl tap_bscan_checker u_chk (
    .tck          (tck),
    .trst         (trst),
    .tms          (tms),
    .tdo_en       (tdo_en),
    .bscan_sel    (bscan_sel),
    .ijtag_sel    (ijtag_sel),
    .bs_force_off (bs_force_off),
    .bs_core_in   (bs_core_in),
    .bs_pin_out   (bs_pin_out),
    .bs_pulse     (bs_pulse),
    .bs_train     (bs_train),
    .cap_dr_en    (cap_dr_en),
    .shift_dr_en  (shift_dr_en),
    .upd_dr_en    (upd_dr_en),
    .tlr_n        (tlr_n),
    .fsm_code     (fsm_code)
);

// File: tb/tap_bscan_ctrl_test.sv
`timescale 1ns/1ps
module tap_bscan_ctrl_test;

    localparam logic [3:0]  T_VER  = 4'h5;
    localparam logic [15:0] T_PART = 16'hA3C9;
    localparam logic [10:0] T_MFR  = 11'h370;
    localparam logic [31:0] T_ID   = {T_VER, T_PART, T_MFR, 1'b1};

    // {opcode, strobes {chain,host,force,core_in,pin_out,pulse,train}, path}
    // path 0 bypass, 1 boundary return, 2 host return, 3 identification
    localparam logic [12:0] VEC [0:11] = '{
        {4'b0000, 7'b0000100, 2'd0},
        {4'b0001, 7'b1000100, 2'd1},
        {4'b0010, 7'b1000110, 2'd1},
        {4'b0011, 7'b1000101, 2'd1},
        {4'b0100, 7'b1001000, 2'd1},
        {4'b0101, 7'b1000000, 2'd1},
        {4'b0110, 7'b0010100, 2'd0},
        {4'b0111, 7'b0100000, 2'd2},
        {4'b1000, 7'b0000000, 2'd3},
        {4'b1111, 7'b0000000, 2'd0},
        {4'b1001, 7'b0000000, 2'd0},
        {4'b1010, 7'b0000000, 2'd0}
    };

    // {tms, expected state code, {capture, shift, update}} walked from idle
    localparam logic [7:0] WALK [0:17] = '{
        {1'b1, 4'b0111, 3'b000}, {1'b0, 4'b0110, 3'b100}, {1'b1, 4'b0001, 3'b000},
        {1'b0, 4'b0011, 3'b000}, {1'b1, 4'b0000, 3'b000}, {1'b0, 4'b0010, 3'b010},
        {1'b1, 4'b0001, 3'b000}, {1'b1, 4'b0101, 3'b001}, {1'b1, 4'b0111, 3'b000},
        {1'b1, 4'b0100, 3'b000}, {1'b0, 4'b1110, 3'b000}, {1'b1, 4'b1001, 3'b000},
        {1'b0, 4'b1011, 3'b000}, {1'b1, 4'b1000, 3'b000}, {1'b0, 4'b1010, 3'b000},
        {1'b1, 4'b1001, 3'b000}, {1'b1, 4'b1101, 3'b000}, {1'b0, 4'b1100, 3'b000}
    };

    logic tck = 1'b0;
    logic trst, tms, tdi, bscan_ret_i, ijtag_ret_i;
    logic tdo, tdo_en, bscan_sel, ijtag_sel, bs_force_off, bs_core_in, bs_pin_out;
    logic bs_pulse, bs_train, cap_dr_en, shift_dr_en, upd_dr_en, tlr_n;
    logic [3:0] fsm_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 tck = ~tck;

    tap_bscan_ctrl #(.ID_VERSION(T_VER), .ID_PART(T_PART), .ID_MFR(T_MFR)) uut (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi),
        .bscan_ret_i(bscan_ret_i), .ijtag_ret_i(ijtag_ret_i),
        .tdo(tdo), .tdo_en(tdo_en),
        .bscan_sel(bscan_sel), .ijtag_sel(ijtag_sel), .bs_force_off(bs_force_off),
        .bs_core_in(bs_core_in), .bs_pin_out(bs_pin_out), .bs_pulse(bs_pulse),
        .bs_train(bs_train), .cap_dr_en(cap_dr_en), .shift_dr_en(shift_dr_en),
        .upd_dr_en(upd_dr_en), .tlr_n(tlr_n), .fsm_code(fsm_code)
    );

    function automatic logic [6:0] strobes();
        return {bscan_sel, ijtag_sel, bs_force_off, bs_core_in, bs_pin_out, bs_pulse, bs_train};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive, pass a rising and a falling edge, settle mid low phase
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic load_ir(input logic [3:0] op);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) tick(i == 3, op[i]);
        tick(1, 0); tick(0, 0);
    endtask

    // returns a three-sample signature that tells the four return sources apart
    task automatic probe_dr(output logic [2:0] sig);
        bscan_ret_i = 0; ijtag_ret_i = 0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        sig[2] = tdo;
        bscan_ret_i = 1; ijtag_ret_i = 0;
        tick(0, 0);
        sig[1] = tdo;
        bscan_ret_i = 0; ijtag_ret_i = 1;
        tick(0, 0);
        sig[0] = tdo;
        ijtag_ret_i = 0;
        tick(1, 0); tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] id_read;
        logic [2:0]  sig;
        logic [3:0]  pat;
        trst = 1; tms = 1; tdi = 0; bscan_ret_i = 0; ijtag_ret_i = 0;
        repeat (3) tick(1, 0);
        trst = 0;

        // R2 / R11 reset state
        chk("R2 reset state code", fsm_code, 4'b1111);
        chk("R11 tlr_n low in reset", tlr_n, 0);
        chk("R11 enables idle in reset", {cap_dr_en, shift_dr_en, upd_dr_en}, 0);
        chk("R12 tdo_en low in reset", tdo_en, 0);
        chk("R9 R10 strobes idle for identification", strobes(), 0);

        // R8 full identification readout
        tick(0, 0);
        chk("R1 idle code", fsm_code, 4'b1100);
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R12 tdo_en in data shift", tdo_en, 1);
        for (int i = 0; i < 32; i++) begin
            id_read[i] = tdo;
            tick(i == 31, 0);
        end
        chk("R12 tdo_en low in exit", tdo_en, 0);
        chk("R8 identification value", id_read, T_ID);
        tick(1, 0); tick(0, 0);

        // R6 / R3 instruction capture pattern, loads bypass
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R12 tdo_en in instruction shift", tdo_en, 1);
        chk("R6 capture bit0", tdo, 1);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, 1);
            if (i < 3) chk("R6 capture upper bits", tdo, 0);
        end
        chk("R3 strobes unchanged before update", strobes(), 0);
        tick(1, 0); tick(0, 0);

        // R7 bypass one-stage delay
        pat = 4'b1011;
        tick(1, 0); tick(0, 0); tick(0, 1);
        chk("R7 bypass captures zero", tdo, 0);
        for (int i = 0; i < 4; i++) begin
            tick(0, pat[i]);
            chk("R7 bypass delay", tdo, pat[i]);
        end
        tick(1, 0); tick(1, 0); tick(0, 0);

        // R1 / R11 / R12 state walk
        for (int i = 0; i < 18; i++) begin
            tick(WALK[i][7], 0);
            chk("R1 state code", fsm_code, WALK[i][6:3]);
            chk("R11 dr enables", {cap_dr_en, shift_dr_en, upd_dr_en}, WALK[i][2:0]);
            chk("R11 tlr_n high outside reset", tlr_n, 1);
            chk("R12 tdo_en only in shift",
                tdo_en, (WALK[i][6:3] == 4'b0010 || WALK[i][6:3] == 4'b1010));
        end

        // R4 R5 R9 R10 opcode vectors
        for (int v = 0; v < 12; v++) begin
            logic [2:0] exp_sig;
            load_ir(VEC[v][12:9]);
            chk("R9 R10 decoded strobes", strobes(), VEC[v][8:2]);
            probe_dr(sig);
            case (VEC[v][1:0])
                2'd0:    exp_sig = 3'b000;
                2'd1:    exp_sig = 3'b010;
                2'd2:    exp_sig = 3'b001;
                default: exp_sig = 3'b100;
            endcase
            chk("R5 R4 data return source", sig, exp_sig);
            chk("R3 strobes hold across data scan", strobes(), VEC[v][8:2]);
        end

        // R2 five tms-high cycles
        load_ir(4'b0001);
        chk("R9 external test selected", bscan_sel, 1);
        repeat (5) tick(1, 0);
        chk("R2 tms reset state", fsm_code, 4'b1111);
        chk("R2 tms reset restores identification", strobes(), 0);
        tick(0, 0);
        probe_dr(sig);
        chk("R2 identification after tms reset", sig, 3'b100);

        // R2 trst in mid scan
        load_ir(4'b0110);
        tick(1, 0); tick(0, 0); tick(0, 0);
        trst = 1;
        tick(0, 0);
        trst = 0;
        chk("R2 trst forces reset code", fsm_code, 4'b1111);
        chk("R2 trst restores identification", strobes(), 0);
        chk("R12 trst clears tdo_en", tdo_en, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule